// File: doc/BRIEF.md
# Oscillator Sub-Band Search Controller

This block picks the oscillator and sub-band that a frequency synthesizer should run on. The synthesizer has three oscillators, and each one is split into sixteen sub-bands. Taken together they form one ordered ladder of 48 bands. The concatenation {oscillator, sub-band} is that band's position on the ladder. After a trigger, the controller loads a starting band. It waits a programmable settling time and then reads a 3-bit window code that reports where the loop tuning voltage sits. It then either accepts the band or moves one rung down or up and waits again.

The starting band is chosen by a selector. It is either the band given on the seed inputs or the band the controller already holds. When the search function is disabled, the block simply passes the seed band through to its outputs. Two flags report the result. One flag says whether the last search locked. The other says whether the controller is idle.

Top module: `vco_band_autoselect`

## Requirements
- R1: After reset the selected band is oscillator 0, sub-band 0. The idle flag is 1 and the lock flag is 0.
- R2: While `en` is 0, the selected band equals the seed inputs one clock later. The lock flag is 0 and the idle flag is 1, and a `start` pulse has no effect.
- R3: With `en` at 1 and `start_from_cur` at 0, a `start` pulse loads the seed band. The idle flag goes to 0 on the next clock.
- R4: With `start_from_cur` at 1, a `start` pulse keeps the currently selected band as the first band tried.
- R5: After each band load, the window code is sampled exactly 2^(WAIT_BASE_LOG2 + 2·`wait_sel`) clocks later. The band stays unchanged until then. The default WAIT_BASE_LOG2 is 8.
- R6: A sampled code from 3'b001 to 3'b110 ends the search. The band is held, the lock flag becomes 1 and the idle flag becomes 1.
- R7: A sampled code of 3'b000 moves one band down and restarts the wait. Moving down from sub-band 0 goes to sub-band 15 of the next lower oscillator.
- R8: A sampled code of 3'b111 moves one band up and restarts the wait. Moving up from sub-band 15 goes to sub-band 0 of the next higher oscillator.
- R9: The search ends with the lock flag at 0 and the idle flag at 1 in two cases: code 3'b000 at oscillator 0 sub-band 0, or code 3'b111 at oscillator 2 sub-band 15. The band stays at that end.
- R10: A `start` pulse during a search abandons it and begins a new search from the newly chosen start band.
- R11: A start band with oscillator code 2'b11 (oscillator shut down) produces no search. The band is shown as loaded, the idle flag stays 1 and the lock flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Search function enable; 0 = manual band |
| start | input | 1 | One-cycle search trigger |
| start_from_cur | input | 1 | 1 = start from held band, 0 = from seed |
| seed_osc | input | 2 | Seed / manual oscillator code |
| seed_sub | input | 4 | Seed / manual sub-band code |
| wait_sel | input | 2 | Settling-time select |
| tune_code | input | 3 | Tuning-voltage window code |
| sel_osc | output | 2 | Selected oscillator |
| sel_sub | output | 4 | Selected sub-band |
| lock_ok | output | 1 | Last search locked |
| idle | output | 1 | 1 = no search running |

## Verification
The hardest situations to reach are the walks that cross an oscillator boundary and the walks that run off either end of the ladder. Both need the tuning code to stay consistent over many bands. The bench models the synthesizer as a target rung on the ladder. It drives 3'b111 below the target, 3'b000 above it and a random lock code at it. Placing the target outside the ladder forces a run to either end. Mid-search restarts and starts from the held band are mixed in with random seeds, targets and wait settings.

// File: rtl/vas_pkg.sv
// Package: shared types and constants for the sub-band search controller.
// Assumes a 2-bit oscillator code and a 4-bit sub-band code.
package vas_pkg;
    localparam int OSC_W  = 2;
    localparam int SUB_W  = 4;
    localparam int CODE_W = 3;

    localparam logic [CODE_W-1:0] CODE_GO_DOWN = 3'b000;
    localparam logic [CODE_W-1:0] CODE_GO_UP   = 3'b111;

    typedef struct packed {
        logic [OSC_W-1:0] osc;
        logic [SUB_W-1:0] sub;
    } band_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } vas_state_t;
endpackage

// File: rtl/vas_wait_timer.sv
// Module: settling-time down-counter.
// On load it starts at 2^(BASE_LOG2 + 2*sel) - 1 and counts to zero;
// expired is high while the count is zero. Assumes BASE_LOG2 >= 1.
module vas_wait_timer #(
    parameter int BASE_LOG2 = 8,
    parameter int SEL_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEL_W-1:0] sel,
    output logic             expired
);
    localparam int MAX_LOG2 = BASE_LOG2 + 2 * ((1 << SEL_W) - 1);
    localparam int CNT_W    = MAX_LOG2;
    localparam int SH_W     = $clog2(MAX_LOG2 + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [SH_W-1:0]  shamt;
    logic [CNT_W:0]   one_hot;
    logic [CNT_W:0]   load_val;

    // Purpose: exponent of the selected wait length.
    assign shamt    = SH_W'(BASE_LOG2) + SH_W'({sel, 1'b0});
    assign one_hot  = (CNT_W + 1)'(1) << shamt;
    assign load_val = one_hot - (CNT_W + 1)'(1);
    assign expired  = (cnt_q == '0);

    // Purpose: load or count the settling interval down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val[CNT_W-1:0];
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R5: a fresh load always gives a nonzero wait
    assert_wait_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !expired);
endmodule

// File: rtl/vas_band_stepper.sv
// Module: computes the neighbouring band in one direction on the ladder.
// UP=1 gives the next higher band, UP=0 the next lower. Sub-band wraps
// move into the adjacent oscillator; at_edge flags the end of the ladder.
// Assumes cur_band holds a valid oscillator (below NUM_OSC).
module vas_band_stepper
    import vas_pkg::*;
#(
    parameter bit UP      = 1'b1,
    parameter int NUM_OSC = 3
) (
    input  band_t cur_band,
    output band_t nxt_band,
    output logic  at_edge
);
    localparam logic [SUB_W-1:0] SUB_MAX = '1;
    localparam logic [OSC_W-1:0] OSC_TOP = OSC_W'(NUM_OSC - 1);

    generate
        if (UP) begin : g_up
            // Purpose: next higher band, wrapping into the next oscillator.
            always_comb begin
                nxt_band = cur_band;
                at_edge  = 1'b0;
                if (cur_band.sub == SUB_MAX) begin
                    if (cur_band.osc >= OSC_TOP) begin
                        at_edge = 1'b1;
                    end else begin
                        nxt_band.osc = cur_band.osc + 1'b1;
                        nxt_band.sub = '0;
                    end
                end else begin
                    nxt_band.sub = cur_band.sub + 1'b1;
                end
            end
        end else begin : g_down
            // Purpose: next lower band, wrapping into the previous oscillator.
            always_comb begin
                nxt_band = cur_band;
                at_edge  = 1'b0;
                if (cur_band.sub == '0) begin
                    if (cur_band.osc == '0) begin
                        at_edge = 1'b1;
                    end else begin
                        nxt_band.osc = cur_band.osc - 1'b1;
                        nxt_band.sub = SUB_MAX;
                    end
                end else begin
                    nxt_band.sub = cur_band.sub - 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/vco_band_autoselect.sv
// Module: oscillator sub-band search controller (top).
// Walks the 48-rung band ladder under control of a 3-bit tuning window
// code, one settling wait per rung. When disabled, it passes the seed
// band straight through. Assumes start is a one-cycle pulse and that
// tune_code is valid whenever a wait expires.
module vco_band_autoselect
    import vas_pkg::*;
#(
    parameter int WAIT_BASE_LOG2 = 8,
    parameter int NUM_OSC        = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              start,
    input  logic              start_from_cur,
    input  logic [OSC_W-1:0]  seed_osc,
    input  logic [SUB_W-1:0]  seed_sub,
    input  logic [1:0]        wait_sel,
    input  logic [CODE_W-1:0] tune_code,
    output logic [OSC_W-1:0]  sel_osc,
    output logic [SUB_W-1:0]  sel_sub,
    output logic              lock_ok,
    output logic              idle
);
    localparam logic [OSC_W-1:0] OSC_TOP = OSC_W'(NUM_OSC - 1);
    localparam logic [SUB_W-1:0] SUB_MAX = '1;

    vas_state_t state_q;
    band_t      band_q;
    logic       ok_q;

    band_t seed_band;
    band_t start_band;
    band_t step_band [2];
    logic  step_edge [2];
    logic  start_valid;
    logic  sample;
    logic  go_dn;
    logic  go_up;
    logic  timer_load;
    logic  expired;

    // Purpose: pick the start band and decode the sampled window code.
    always_comb begin
        seed_band   = '{osc: seed_osc, sub: seed_sub};
        start_band  = start_from_cur ? band_q : seed_band;
        start_valid = (start_band.osc <= OSC_TOP);
        sample      = (state_q == ST_WAIT) && expired;
        go_dn       = sample && (tune_code == CODE_GO_DOWN) && !step_edge[0];
        go_up       = sample && (tune_code == CODE_GO_UP) && !step_edge[1];
        timer_load  = en && (start ? start_valid : (go_dn || go_up));
    end

    generate
        for (genvar d = 0; d < 2; d++) begin : g_step
            vas_band_stepper #(
                .UP      (d == 1),
                .NUM_OSC (NUM_OSC)
            ) u_step (
                .cur_band (band_q),
                .nxt_band (step_band[d]),
                .at_edge  (step_edge[d])
            );
        end
    endgenerate

    vas_wait_timer #(
        .BASE_LOG2 (WAIT_BASE_LOG2),
        .SEL_W     (2)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (timer_load),
        .sel     (wait_sel),
        .expired (expired)
    );

    // Purpose: search state, current band and lock result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            band_q  <= '0;
            ok_q    <= 1'b0;
        end else if (!en) begin
            state_q <= ST_IDLE;
            band_q  <= seed_band;
            ok_q    <= 1'b0;
        end else if (start) begin
            ok_q    <= 1'b0;
            band_q  <= start_band;
            state_q <= start_valid ? ST_WAIT : ST_IDLE;
        end else if (sample) begin
            if (tune_code == CODE_GO_DOWN) begin
                if (step_edge[0]) begin
                    state_q <= ST_IDLE;
                end else begin
                    band_q <= step_band[0];
                end
            end else if (tune_code == CODE_GO_UP) begin
                if (step_edge[1]) begin
                    state_q <= ST_IDLE;
                end else begin
                    band_q <= step_band[1];
                end
            end else begin
                ok_q    <= 1'b1;
                state_q <= ST_IDLE;
            end
        end
    end

    assign sel_osc = band_q.osc;
    assign sel_sub = band_q.sub;
    assign lock_ok = ok_q;
    assign idle    = (state_q == ST_IDLE);

    // R6: a lock result is only reported once the search has stopped
    assert_lock_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_ok |-> idle);

    // R2: disabled means pass-through, no lock, idle
    assert_manual_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ({sel_osc, sel_sub} == $past({seed_osc, seed_sub}) && !lock_ok && idle));

    // R3: a seeded valid start makes the controller busy on the seed band
    assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && start && !start_from_cur && seed_osc <= OSC_TOP)
        |=> (!idle && {sel_osc, sel_sub} == $past({seed_osc, seed_sub})));

    // R5: band holds while settling
    assert_band_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !start && !idle && !expired) |=> $stable({sel_osc, sel_sub}));

    // R8: an up step advances the ladder position by one
    assert_step_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !start && !idle && expired && tune_code == CODE_GO_UP
         && !(sel_osc == OSC_TOP && sel_sub == SUB_MAX))
        |=> ({sel_osc, sel_sub} == $past({sel_osc, sel_sub}) + 1'b1 && !idle));

    // R7: a down step lowers the ladder position by one
    assert_step_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !start && !idle && expired && tune_code == CODE_GO_DOWN
         && !(sel_osc == '0 && sel_sub == '0))
        |=> ({sel_osc, sel_sub} == $past({sel_osc, sel_sub}) - 1'b1 && !idle));

    // R9: running off the top of the ladder fails and holds the band
    assert_top_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !start && !idle && expired && tune_code == CODE_GO_UP
         && sel_osc == OSC_TOP && sel_sub == SUB_MAX)
        |=> (idle && !lock_ok && $stable({sel_osc, sel_sub})));
endmodule

// File: tb/vco_band_autoselect_tb.sv
`timescale 1ns/1ps
module vco_band_autoselect_tb_top;
    localparam int BASE = 2;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       en;
    logic       start;
    logic       start_from_cur;
    logic [1:0] seed_osc;
    logic [3:0] seed_sub;
    logic [1:0] wait_sel;
    logic [2:0] tune_code;
    logic [1:0] sel_osc;
    logic [3:0] sel_sub;
    logic       lock_ok;
    logic       idle;

    int         tgt = 48;
    logic [2:0] lock_code = 3'b011;
    int         n_checks = 0;
    int         n_err = 0;
    int         idx_now;

    always #2 clk = ~clk;

    vco_band_autoselect #(.WAIT_BASE_LOG2(BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .start(start),
        .start_from_cur(start_from_cur), .seed_osc(seed_osc), .seed_sub(seed_sub),
        .wait_sel(wait_sel), .tune_code(tune_code), .sel_osc(sel_osc),
        .sel_sub(sel_sub), .lock_ok(lock_ok), .idle(idle)
    );

    // Synthesizer model: target rung on the ladder.
    always_comb begin
        idx_now = int'({sel_osc, sel_sub});
        if (idx_now < tgt)      tune_code = 3'b111;
        else if (idx_now > tgt) tune_code = 3'b000;
        else                    tune_code = lock_code;
    end

    function automatic int exp_samples(int s, int t);
        if (t < 0)  return s + 1;
        if (t > 47) return 48 - s;
        return ((t > s) ? t - s : s - t) + 1;
    endfunction

    function automatic int exp_band(int t);
        if (t < 0)  return 0;
        if (t > 47) return 47;
        return t;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    // Full search: start, check busy/band, wait-window timing, result.
    task automatic run(int seed_i, bit from_cur, int t, int sel, string req);
        int cur = int'({sel_osc, sel_sub});
        int st  = from_cur ? cur : seed_i;
        int k   = exp_samples(st, t);
        int n   = 1 << (BASE + 2 * sel);
        @(negedge clk);
        seed_osc = 2'(seed_i >> 4);
        seed_sub = 4'(seed_i);
        start_from_cur = from_cur;
        wait_sel = 2'(sel);
        tgt = t;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(from_cur ? "R4 start band" : "R3 start band", int'({sel_osc, sel_sub}), st);
        chk("R3 busy after start", int'(idle), 0);
        repeat (n - 1) @(negedge clk);
        chk("R5 band held through wait", int'({sel_osc, sel_sub}), st);
        repeat ((k - 1) * n) @(negedge clk);
        chk("R5 still busy before last sample", int'(idle), 0);
        @(negedge clk);
        chk({req, " idle at end"}, int'(idle), 1);
        chk({req, " lock flag"}, int'(lock_ok), (t >= 0 && t <= 47) ? 1 : 0);
        chk({req, " final band"}, int'({sel_osc, sel_sub}), exp_band(t));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int unsigned r;
        r = $urandom(32'd2024);
        rst_n = 1'b0; en = 1'b1; start = 1'b0; start_from_cur = 1'b0;
        seed_osc = 2'd0; seed_sub = 4'd0; wait_sel = 2'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset band", int'({sel_osc, sel_sub}), 0);
        chk("R1 reset idle", int'(idle), 1);
        chk("R1 reset lock", int'(lock_ok), 0);

        // R6 plain lock on first band, R7/R8 oscillator crossings
        run(10, 1'b0, 10, 0, "R6");
        run(16, 1'b0, 15, 0, "R7 cross down");
        run(15, 1'b0, 16, 1, "R8 cross up");
        run(40, 1'b0, 5, 0, "R7 long walk");
        run(3, 1'b0, 44, 0, "R8 long walk");
        // R9 ladder ends
        run(0, 1'b0, -1, 0, "R9 bottom");
        run(47, 1'b0, 48, 0, "R9 top");
        run(20, 1'b0, -1, 0, "R9 run to bottom");
        run(30, 1'b0, 48, 0, "R9 run to top");
        // R5 longer waits
        run(10, 1'b0, 11, 2, "R5 wait sel2");
        run(33, 1'b0, 32, 3, "R5 wait sel3");
        // R4 start from held band (ends at 32 above)
        run(5, 1'b1, 35, 0, "R4");

        // R10 restart mid-search
        @(negedge clk);
        seed_osc = 2'd0; seed_sub = 4'd0; start_from_cur = 1'b0;
        wait_sel = 2'd0; tgt = 47; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        chk("R10 first search busy", int'(idle), 0);
        run(25, 1'b0, 20, 0, "R10 restart");

        // R2 disabled pass-through, start ignored
        @(negedge clk);
        en = 1'b0; seed_osc = 2'd2; seed_sub = 4'd5;
        @(negedge clk);
        chk("R2 follows seed", int'({sel_osc, sel_sub}), 37);
        chk("R2 lock low", int'(lock_ok), 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 start ignored", int'(idle), 1);
        seed_osc = 2'd1; seed_sub = 4'd9;
        @(negedge clk);
        chk("R2 follows new seed", int'({sel_osc, sel_sub}), 25);
        en = 1'b1;

        // R11 shut-down oscillator code as start band
        @(negedge clk);
        seed_osc = 2'd3; seed_sub = 4'd5; start_from_cur = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R11 band loaded", int'({sel_osc, sel_sub}), 53);
        chk("R11 no search", int'(idle), 1);
        chk("R11 lock low", int'(lock_ok), 0);
        start_from_cur = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R11 from held shut-down band", int'(idle), 1);

        // Reload a valid band, then random searches
        run(12, 1'b0, 12, 0, "R6 reload");
        for (int i = 0; i < 25; i++) begin
            int s    = int'($urandom_range(0, 47));
            int mode = int'($urandom_range(0, 9));
            int t    = (mode == 0) ? -1 : (mode == 1) ? 48 : int'($urandom_range(0, 47));
            bit fc   = 1'($urandom_range(0, 1));
            lock_code = 3'($urandom_range(1, 6));
            run(s, fc, t, int'($urandom_range(0, 1)), "R6-R9 random");
        end

        finish_run();
    end
endmodule